// File: doc/BRIEF.md
# Serial Configuration Word with Readback Stream

This block holds a 12-bit configuration word that is loaded through a dedicated serial clock and data pair, and decodes it into the mode fields used by the rest of the chip. A load is allowed only in the configuration phase that follows reset while the conversion control line is low. Bits arrive most significant first and are taken on the falling edge of the configuration clock. The stored word changes only when a full 12-bit word has arrived.

Once a word is complete, the host can clock a readback stream out on the data clock. Each rising edge of that clock presents one bit. The stream holds the stored word, a 4-bit revision code and a fixed test pattern that sits at the tail of a zero-padded frame. The frame is sent twice. A rising edge of the conversion control line closes the configuration phase and starts normal operation. All pins are sampled on the system clock `clk`, which must run well above the serial clocks. Edges are found by comparing each pin with its value from the previous cycle.

Top module: `cfgrb_top`

## Requirements
- R1: After reset the outputs are range_sel=3'b111, wide_fmt=1, high_speed=0, clk_div4=0, test_en=0 and rb_dout=0 (stored word 12'hF00).
- R2: On each falling edge of cfg_sclk in the configuration phase, one bit of cfg_sdata is taken, most significant first. The decoded outputs change only after the 12th bit. They come from the word as range_sel=[11:9], wide_fmt=[8], high_speed=[7], clk_div4=[6] and test_en=[0].
- R3: If fewer than 12 bits arrive before the configuration phase ends, the stored word does not change.
- R4: Bits [5:1] of the stored word are always zero, whatever value was written to them.
- R5: After a complete word, each rising edge of dclk presents the next readback bit on rb_dout. The order is the 12 word bits from the MSB, then the 4 revision bits from the MSB, then zeros, then the test pattern at the end of the frame. A frame is 256 bits when wide_fmt=0 and 320 bits when wide_fmt=1.
- R6: The test pattern is 56'h30F066012480F6 when wide_fmt=0 and 72'h30F066012480F69055 when wide_fmt=1, sent MSB first.
- R7: The frame is sent twice, giving 512 or 640 bits in total. Any later dclk rising edge drives rb_dout to 0.
- R8: A rising edge of conv ends the configuration phase for good until the next reset. After it, rb_dout is 0 and cfg_sclk and dclk edges have no effect on the stored word or on rb_dout.
- R9: Reset is asynchronous and active low. It restores the R1 values and reopens the configuration phase.
- R10: Before the first complete word after reset, dclk edges leave rb_dout at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sclk | input | 1 | Configuration serial clock; bits are taken on its falling edge |
| cfg_sdata | input | 1 | Configuration serial data, MSB first |
| conv | input | 1 | Conversion control level; a rising edge leaves the configuration phase |
| dclk | input | 1 | Data clock; a rising edge advances the readback stream |
| range_sel | output | 3 | Decoded range field |
| wide_fmt | output | 1 | Output word format (1 = wide) |
| high_speed | output | 1 | Power/speed mode (1 = high speed) |
| clk_div4 | output | 1 | System clock divide-by-4 enable |
| test_en | output | 1 | Test mode enable |
| rb_dout | output | 1 | Serial readback bit |

## Verification
The assertions check on every cycle that the reserved bits stay clear and that the stored word moves only on a word-complete event. They also check that the normal phase, once entered, is never left and accepts no word, and that rb_dout changes only on a data-clock edge, a word completion or the conv edge. The bench scenarios are needed for the actual bit content: the MSB-first capture, the frame order and its padding, both pattern lengths, the second copy and the quiet output after it. The same holds for a partial write being discarded and for readback staying silent before a first word.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;
  localparam int CFG_W        = 12;
  localparam int REV_W        = 4;
  localparam int HDR_W        = CFG_W + REV_W;
  localparam int PAT_W_WIDE   = 72;
  localparam int PAT_W_NARROW = 56;
  localparam int SEQ_WIDE     = 320;
  localparam int SEQ_NARROW   = 256;
  localparam int IDX_W        = $clog2(SEQ_WIDE + 1);

  localparam logic [PAT_W_WIDE-1:0] TEST_PATTERN = 72'h30F066012480F69055;
  localparam logic [CFG_W-1:0]      CFG_DEFAULT  = 12'hF00;
  localparam logic [CFG_W-1:0]      CFG_RSV_MASK = 12'h03E;

  typedef logic [CFG_W-1:0]                cfg_word_t;
  typedef logic [$clog2(CFG_W)-1:0]        cfg_sel_t;
  typedef logic [$clog2(REV_W)-1:0]        rev_sel_t;
  typedef logic [$clog2(PAT_W_WIDE)-1:0]   pat_sel_t;
  typedef logic [IDX_W-1:0]                idx_t;

  typedef struct packed {
    logic [2:0] range_sel;
    logic       wide_fmt;
    logic       high_speed;
    logic       div4;
    logic       test_en;
  } cfg_fields_t;

  // Field positions are fixed: other blocks decode them.
  function automatic cfg_fields_t decode_cfg(input cfg_word_t w);
    cfg_fields_t f;
    f.range_sel  = w[11:9];
    f.wide_fmt   = w[8];
    f.high_speed = w[7];
    f.div4       = w[6];
    f.test_en    = w[0];
    return f;
  endfunction

  function automatic cfg_word_t sanitize(input cfg_word_t w);
    return w & ~CFG_RSV_MASK;
  endfunction

  function automatic idx_t frame_len(input logic wide);
    return wide ? idx_t'(SEQ_WIDE) : idx_t'(SEQ_NARROW);
  endfunction

  // Bit k of one readback frame: word, revision, zero padding, tail pattern.
  function automatic logic rb_bit(input cfg_word_t w, input logic [REV_W-1:0] rev,
                                  input logic wide, input idx_t k);
    int kk;
    int plen;
    int pad_end;
    kk      = int'(k);
    plen    = wide ? PAT_W_WIDE : PAT_W_NARROW;
    pad_end = (wide ? SEQ_WIDE : SEQ_NARROW) - plen;
    if (kk < CFG_W)   return w[cfg_sel_t'(CFG_W - 1 - kk)];
    if (kk < HDR_W)   return rev[rev_sel_t'(HDR_W - 1 - kk)];
    if (kk < pad_end) return 1'b0;
    return TEST_PATTERN[pat_sel_t'(PAT_W_WIDE - 1 - (kk - pad_end))];
  endfunction
endpackage

// File: rtl/cfgrb_edge.sv
module cfgrb_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= pins;
  end

  assign rise = pins & ~prev;
  assign fall = ~pins & prev;
endmodule

// File: rtl/cfgrb_shift_in.sv
module cfgrb_shift_in
  import cfgrb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic      bit_in,
  output logic      word_done,
  output cfg_word_t word
);
  localparam int CNT_W = $clog2(CFG_W);

  logic [CNT_W-1:0] cnt;
  cfg_word_t        sh;

  assign word      = {sh[CFG_W-2:0], bit_in};
  assign word_done = take && (cnt == CNT_W'(CFG_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (take) begin
      sh  <= word;
      cnt <= word_done ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cfgrb_readback.sv
module cfgrb_readback
  import cfgrb_pkg::*;
#(
  parameter logic [REV_W-1:0] REV_ID  = 4'h1,
  parameter int               REPEATS = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stop,
  input  logic      restart,
  input  logic      step,
  input  cfg_word_t cfg,
  output logic      dout
);
  localparam int REP_W = $clog2(REPEATS + 1);

  logic             armed;
  idx_t             idx;
  logic [REP_W-1:0] rep;
  logic             wide;
  idx_t             last_idx;
  logic             stream_end;

  assign wide       = decode_cfg(cfg).wide_fmt;
  assign last_idx   = idx_t'(frame_len(wide) - idx_t'(1));
  assign stream_end = (rep == REP_W'(REPEATS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      idx   <= '0;
      rep   <= '0;
      dout  <= 1'b0;
    end else if (stop) begin
      armed <= 1'b0;
      idx   <= '0;
      rep   <= '0;
      dout  <= 1'b0;
    end else if (restart) begin
      armed <= 1'b1;
      idx   <= '0;
      rep   <= '0;
      dout  <= 1'b0;
    end else if (step && armed) begin
      if (stream_end) begin
        dout <= 1'b0;
      end else begin
        dout <= rb_bit(cfg, REV_ID, wide, idx);
        if (idx == last_idx) begin
          idx <= '0;
          rep <= rep + REP_W'(1);
        end else begin
          idx <= idx + idx_t'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cfgrb_top.sv
module cfgrb_top
  import cfgrb_pkg::*;
#(
  parameter logic [REV_W-1:0] REV_ID  = 4'h1,
  parameter int               REPEATS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_sclk,
  input  logic       cfg_sdata,
  input  logic       conv,
  input  logic       dclk,
  output logic [2:0] range_sel,
  output logic       wide_fmt,
  output logic       high_speed,
  output logic       clk_div4,
  output logic       test_en,
  output logic       rb_dout
);
  logic [2:0]  pin_rise;
  logic [2:0]  pin_fall;
  logic        conv_rise;
  logic        dclk_rise;
  logic        cfg_fall;
  logic        cfg_mode;
  logic        cfg_take;
  logic        rb_step;
  logic        word_done;
  cfg_word_t   word_in;
  cfg_word_t   cfg_q;
  cfg_fields_t fields;

  cfgrb_edge #(.N(3)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pins  ({conv, dclk, cfg_sclk}),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  assign conv_rise = pin_rise[2];
  assign dclk_rise = pin_rise[1];
  assign cfg_fall  = pin_fall[0];
  assign cfg_take  = cfg_fall  && cfg_mode && !conv_rise;
  assign rb_step   = dclk_rise && cfg_mode && !conv_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_mode <= 1'b1;
    else if (conv_rise) cfg_mode <= 1'b0;
  end

  cfgrb_shift_in u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (cfg_take),
    .bit_in    (cfg_sdata),
    .word_done (word_done),
    .word      (word_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= CFG_DEFAULT;
    else if (word_done) cfg_q <= sanitize(word_in);
  end

  cfgrb_readback #(.REV_ID(REV_ID), .REPEATS(REPEATS)) u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop    (conv_rise),
    .restart (word_done),
    .step    (rb_step),
    .cfg     (cfg_q),
    .dout    (rb_dout)
  );

  assign fields     = decode_cfg(cfg_q);
  assign range_sel  = fields.range_sel;
  assign wide_fmt   = fields.wide_fmt;
  assign high_speed = fields.high_speed;
  assign clk_div4   = fields.div4;
  assign test_en    = fields.test_en;
endmodule

// File: rtl/cfgrb_checker.sv
module cfgrb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_mode,
  input logic        conv_rise,
  input logic        dclk_rise,
  input logic        word_done,
  input logic [11:0] cfg_q,
  input logic        rb_dout
);
  AST_RSV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[5:1] == 5'd0); // R4

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(cfg_q)); // R2

  AST_NORMAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> !cfg_mode); // R8

  AST_NORMAL_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> !word_done); // R8

  AST_NORMAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> !rb_dout); // R8

  AST_DOUT_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!dclk_rise && !word_done && !conv_rise) |=> $stable(rb_dout)); // R5
endmodule

bind cfgrb_top cfgrb_checker u_chk (.*);

// File: tb/cfgrb_top_test.sv
module cfgrb_top_test;
  localparam logic [3:0]  REV = 4'h1;
  localparam logic [71:0] PAT = 72'h30F066012480F69055;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_sclk = 1'b0, cfg_sdata = 1'b0, conv = 1'b0, dclk = 1'b0;
  logic [2:0] range_sel;
  logic wide_fmt, high_speed, clk_div4, test_en, rb_dout;

  always #10 clk = ~clk;

  cfgrb_top #(.REV_ID(REV)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_sclk(cfg_sclk), .cfg_sdata(cfg_sdata),
    .conv(conv), .dclk(dclk), .range_sel(range_sel), .wide_fmt(wide_fmt),
    .high_speed(high_speed), .clk_div4(clk_div4), .test_en(test_en), .rb_dout(rb_dout)
  );

  int    checks = 0, failures = 0;
  string cur_req = "R1";
  bit    done = 1'b0;
  logic  rbuf [0:639];

  // Behavioural reference model
  logic [11:0] m_cfg, m_sh;
  int          m_cnt;
  bit          m_mode, m_armed, m_wd;
  logic        m_dout;
  bit          q [$];
  logic        p_sclk, p_dclk, p_conv;
  bit          e_fall, e_drise, e_crise;

  task automatic m_reset();
    m_cfg = 12'hF00; m_sh = '0; m_cnt = 0; m_mode = 1; m_armed = 0;
    m_dout = 0; q.delete(); p_sclk = 0; p_dclk = 0; p_conv = 0;
  endtask

  task automatic m_fill();
    int seq, plen;
    seq  = m_cfg[8] ? 320 : 256;
    plen = m_cfg[8] ? 72 : 56;
    q.delete();
    for (int r = 0; r < 2; r++) begin
      for (int i = 11; i >= 0; i--) q.push_back(m_cfg[i]);
      for (int i = 3; i >= 0; i--) q.push_back(REV[i]);
      for (int i = 0; i < seq - 16 - plen; i++) q.push_back(1'b0);
      for (int i = 0; i < plen; i++) q.push_back(PAT[71 - i]);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      e_fall  = p_sclk && !cfg_sclk;
      e_drise = !p_dclk && dclk;
      e_crise = !p_conv && conv;
      p_sclk = cfg_sclk; p_dclk = dclk; p_conv = conv;
      m_wd = 0;
      if (e_crise) begin
        m_mode = 0; m_armed = 0; m_dout = 0; q.delete();
      end else if (m_mode) begin
        if (e_fall) begin
          m_sh = {m_sh[10:0], cfg_sdata};
          m_cnt++;
          if (m_cnt == 12) begin
            m_cfg = m_sh & 12'hFC1; m_cnt = 0; m_armed = 1; m_dout = 0; m_wd = 1;
            m_fill();
          end
        end
        if (!m_wd && e_drise && m_armed)
          m_dout = (q.size() > 0) ? q.pop_front() : 1'b0;
      end
    end
  end

  task automatic chk(string req, string what, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "cycle dout", 72'(rb_dout), 72'(m_dout));
      chk(cur_req, "cycle fields", 72'({range_sel, wide_fmt, high_speed, clk_div4, test_en}),
          72'({m_cfg[11:9], m_cfg[8], m_cfg[7], m_cfg[6], m_cfg[0]}));
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic send_bit(logic b);
    cfg_sdata = b; cfg_sclk = 1'b1; tick();
    cfg_sclk = 1'b0; tick();
  endtask

  task automatic send_word(logic [11:0] w, int nbits);
    for (int i = 11; i > 11 - nbits; i--) send_bit(w[i]);
  endtask

  task automatic pulse_read(int n);
    for (int i = 0; i < n; i++) begin
      dclk = 1'b1; tick();
      if (i < 640) rbuf[i] = rb_dout;
      dclk = 1'b0; tick();
    end
  endtask

  function automatic logic [71:0] grab(int start, int len);
    logic [71:0] v = '0;
    for (int i = 0; i < len; i++) v = {v[70:0], rbuf[start + i]};
    return v;
  endfunction

  function automatic int ones_in(int start, int len);
    int c = 0;
    for (int i = 0; i < len; i++) c += int'(rbuf[start + i]);
    return c;
  endfunction

  function automatic int copy_diff(int len);
    int c = 0;
    for (int i = 0; i < len; i++) if (rbuf[i] !== rbuf[len + i]) c++;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; repeat (3) tick(); rst_n = 1'b1; tick();
    @(negedge clk);
    chk("R1", "reset fields", 72'({range_sel, wide_fmt, high_speed, clk_div4, test_en}), 72'(7'b1111000));
    chk("R1", "reset dout", 72'(rb_dout), 72'(0));

    cur_req = "R10";
    pulse_read(4);
    chk("R10", "dout before word", 72'(ones_in(0, 4)), 72'(0));

    cur_req = "R2";
    send_word(12'h4EB, 11);
    @(negedge clk);
    chk("R2", "fields after 11 bits", 72'({range_sel, wide_fmt, high_speed, clk_div4, test_en}), 72'(7'b1111000));
    send_bit(1'b1);
    @(negedge clk);
    chk("R2", "fields after 12 bits", 72'({range_sel, wide_fmt, high_speed, clk_div4, test_en}), 72'(7'b0100111));

    cur_req = "R5";
    pulse_read(512);
    chk("R4", "readback word reserved clear", grab(0, 12), 72'h4C1);
    chk("R5", "revision bits", grab(12, 4), 72'(REV));
    chk("R5", "padding zero", 72'(ones_in(16, 184)), 72'(0));
    chk("R6", "narrow pattern", grab(200, 56), 72'h30F066012480F6);
    chk("R7", "second frame equal", 72'(copy_diff(256)), 72'(0));
    cur_req = "R7";
    pulse_read(3);
    chk("R7", "dout after stream", 72'(ones_in(0, 3)), 72'(0));

    cur_req = "R6";
    send_word(12'hF01, 12);
    pulse_read(640);
    chk("R6", "wide word", grab(0, 12), 72'hF01);
    chk("R6", "wide padding zero", 72'(ones_in(16, 232)), 72'(0));
    chk("R6", "wide pattern", grab(248, 72), PAT);
    chk("R7", "wide second frame equal", 72'(copy_diff(320)), 72'(0));

    cur_req = "R8";
    conv = 1'b1; tick(); tick();
    send_word(12'h000, 12);
    pulse_read(20);
    @(negedge clk);
    chk("R8", "fields frozen", 72'({range_sel, wide_fmt, high_speed, clk_div4, test_en}), 72'(7'b1111001));
    chk("R8", "dout quiet", 72'(ones_in(0, 20)), 72'(0));

    cur_req = "R9";
    conv = 1'b0; rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    @(negedge clk);
    chk("R9", "fields after reset", 72'({range_sel, wide_fmt, high_speed, clk_div4, test_en}), 72'(7'b1111000));

    cur_req = "R3";
    send_word(12'h000, 7);
    conv = 1'b1; tick(); tick();
    send_bit(1'b0); send_bit(1'b0);
    @(negedge clk);
    chk("R3", "partial write dropped", 72'({range_sel, wide_fmt, high_speed, clk_div4, test_en}), 72'(7'b1111000));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule